// File: doc/BRIEF.md
# Display Bridge Power-Up and Hot-Plug Sequencer

This block brings a display bridge out of its powered-down state and hands off to the video path. It drives the bridge's power-down and reset lines and then waits for the hot-plug indication from the bridge. After that it raises a ready flag and fires a one-cycle video-enable strobe. Every delay is counted in ticks of an external one-millisecond enable pulse, so the clock frequency does not affect the timing.

After a resume request, the power-down line is released and reset stays asserted for a short first pulse. Reset is then released for a gap and asserted a second time. After the final release the block waits a settling time and then polls the hot-plug bit. The first hot-plug assertion after a reset costs an extra delay. Later assertions, for example when hot-plug drops and returns while the link is active, go straight to the enable strobe. If hot-plug never arrives, a bounded wait sets a warning flag and the enable step happens anyway. A suspend request asserts reset and then power-down, and it aborts any sequence in progress.

Top module: `bridge_pwr_seq`

## Requirements
- R1: While reset is held and after it is released with no request, powerDown=1, resetOut=1, ready=0, videoEn=0 and hpdWarn=0.
- R2: A resume request while idle (suspendReq low) drops powerDown on the next edge. resetOut then stays 1 for RST1_MS ticks, goes 0 for GAP_MS ticks, goes 1 for RST2_MS ticks, and then goes 0.
- R3: After the final reset release, the block waits SETTLE_MS ticks and then begins polling hot-plug. Hot-plug is bit 1 of the 8-bit gpioStatus input, and the other seven bits have no effect.
- R4: The first hot-plug-high sample after the double reset starts an extra POST_HPD_MS-tick delay, after which videoEn pulses.
- R5: A later hot-plug-high sample, with no reset since the first one, gives a videoEn pulse on the following clock edge with no extra delay.
- R6: If hot-plug stays low for HPD_TMO_MS ticks of polling, hpdWarn goes to 1 and videoEn pulses anyway. hpdWarn holds until the next accepted resume request clears it.
- R7: A suspend request in any active state first gives one cycle with resetOut=1 and powerDown=0, and then returns to powerDown=1 and resetOut=1.
- R8: suspendReq takes priority over resumeReq and aborts any resume, hot-plug wait or active state on the next edge.
- R9: videoEn is high for exactly one cycle, and ready rises on the edge after it and stays 1 until suspend or a hot-plug fall.
- R10: A resume request outside the idle state has no effect on any output.
- R11: While ready is 1, a high-to-low transition of the hot-plug bit drops ready and restarts the bounded hot-plug wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tickMs | input | 1 | One-cycle pulse per millisecond |
| resumeReq | input | 1 | Request to power up and sequence the bridge |
| suspendReq | input | 1 | Request to power down the bridge |
| gpioStatus | input | 8 | Status byte from the bridge; bit 1 is hot-plug |
| powerDown | output | 1 | Power-down line to the bridge, active high |
| resetOut | output | 1 | Reset line to the bridge, active high |
| ready | output | 1 | Video path running |
| videoEn | output | 1 | One-cycle strobe to enable the video path |
| hpdWarn | output | 1 | Hot-plug wait timed out since the last resume |

## Verification
All outputs are decoded from the registered state, so a change at an input or a tick takes effect on the very next rising edge. A duration of N milliseconds is exactly N tick pulses counted while in that state. The bench keeps a behavioural model that advances on the same edge from the same sampled inputs. It compares all five outputs at every falling edge, half a period after the edge where they change. The directed checks sample one falling edge after each stimulus: immediately for a suspend, a later hot-plug, or an ignored resume, and on the second falling edge for the power-down half of a suspend.

// File: rtl/bps_pkg.sv
package bps_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_SUSRST, ST_RST1, ST_GAP, ST_RST2,
    ST_SETTLE, ST_HPDWAIT, ST_POSTHPD, ST_ENABLE, ST_ACTIVE
  } seqState_t;

  typedef enum logic [2:0] {
    LIM_RST1, LIM_GAP, LIM_RST2, LIM_SETTLE, LIM_HPDTMO, LIM_POST
  } limSel_t;

  typedef struct packed {
    logic    clrTimer;
    logic    runTimer;
    limSel_t limSel;
    logic    armFirst;
    logic    useFirst;
    logic    setWarn;
    logic    clrWarn;
  } seqCtl_t;
endpackage

// File: rtl/bps_datapath.sv
module bps_datapath import bps_pkg::*; #(
  parameter int RST1_MS     = 2,
  parameter int GAP_MS      = 50,
  parameter int RST2_MS     = 50,
  parameter int SETTLE_MS   = 200,
  parameter int HPD_TMO_MS  = 200,
  parameter int POST_HPD_MS = 50,
  parameter int STAT_W      = 8,
  parameter int HPD_BIT     = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tickMs,
  input  logic [STAT_W-1:0] gpioStatus,
  input  seqCtl_t           ctl,
  output logic              timerDone,
  output logic              firstPending,
  output logic              hpdLevel,
  output logic              hpdFell,
  output logic              warnFlag
);
  localparam int MAXA   = (RST1_MS > GAP_MS) ? RST1_MS : GAP_MS;
  localparam int MAXB   = (RST2_MS > SETTLE_MS) ? RST2_MS : SETTLE_MS;
  localparam int MAXC   = (HPD_TMO_MS > POST_HPD_MS) ? HPD_TMO_MS : POST_HPD_MS;
  localparam int MAXAB  = (MAXA > MAXB) ? MAXA : MAXB;
  localparam int MAXLIM = (MAXAB > MAXC) ? MAXAB : MAXC;
  localparam int CW     = $clog2(MAXLIM + 1);

  logic [CW-1:0] msCnt;
  logic [CW-1:0] limit;
  logic          hpdPrev;
  logic          unusedStatus;

  assign unusedStatus = ^gpioStatus;
  assign hpdLevel     = gpioStatus[HPD_BIT];
  assign hpdFell      = hpdPrev & ~hpdLevel;

  always_comb begin
    case (ctl.limSel)
      LIM_RST1:   limit = CW'(RST1_MS);
      LIM_GAP:    limit = CW'(GAP_MS);
      LIM_RST2:   limit = CW'(RST2_MS);
      LIM_SETTLE: limit = CW'(SETTLE_MS);
      LIM_HPDTMO: limit = CW'(HPD_TMO_MS);
      default:    limit = CW'(POST_HPD_MS);
    endcase
  end

  assign timerDone = ctl.runTimer & tickMs & (msCnt == limit - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msCnt        <= '0;
      hpdPrev      <= 1'b0;
      firstPending <= 1'b0;
      warnFlag     <= 1'b0;
    end else begin
      hpdPrev <= hpdLevel;
      if (ctl.clrTimer)                msCnt <= '0;
      else if (ctl.runTimer && tickMs) msCnt <= msCnt + CW'(1);
      if (ctl.armFirst)      firstPending <= 1'b1;
      else if (ctl.useFirst) firstPending <= 1'b0;
      if (ctl.clrWarn)       warnFlag <= 1'b0;
      else if (ctl.setWarn)  warnFlag <= 1'b1;
    end
  end

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msCnt < CW'(MAXLIM));

  // R4
  first_used_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.useFirst && !ctl.armFirst) |=> !firstPending);
endmodule

// File: rtl/bps_ctrl.sv
module bps_ctrl import bps_pkg::*; (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    resumeReq,
  input  logic    suspendReq,
  input  logic    timerDone,
  input  logic    firstPending,
  input  logic    hpdLevel,
  input  logic    hpdFell,
  output seqCtl_t ctl,
  output logic    powerDown,
  output logic    resetOut,
  output logic    ready,
  output logic    videoEn
);
  seqState_t st, nxt;
  seqCtl_t   c;

  always_comb begin
    nxt      = st;
    c        = '0;
    c.limSel = LIM_RST1;
    if (suspendReq && st != ST_IDLE && st != ST_SUSRST) begin
      nxt = ST_SUSRST;
    end else begin
      case (st)
        ST_IDLE: if (resumeReq && !suspendReq) begin
          nxt = ST_RST1; c.clrWarn = 1'b1;
        end
        ST_SUSRST: nxt = ST_IDLE;
        ST_RST1: begin
          c.runTimer = 1'b1; c.limSel = LIM_RST1;
          if (timerDone) nxt = ST_GAP;
        end
        ST_GAP: begin
          c.runTimer = 1'b1; c.limSel = LIM_GAP;
          if (timerDone) nxt = ST_RST2;
        end
        ST_RST2: begin
          c.runTimer = 1'b1; c.limSel = LIM_RST2;
          if (timerDone) begin nxt = ST_SETTLE; c.armFirst = 1'b1; end
        end
        ST_SETTLE: begin
          c.runTimer = 1'b1; c.limSel = LIM_SETTLE;
          if (timerDone) nxt = ST_HPDWAIT;
        end
        ST_HPDWAIT: begin
          c.runTimer = 1'b1; c.limSel = LIM_HPDTMO;
          if (hpdLevel) begin
            if (firstPending) begin nxt = ST_POSTHPD; c.useFirst = 1'b1; end
            else nxt = ST_ENABLE;
          end else if (timerDone) begin
            nxt = ST_ENABLE; c.setWarn = 1'b1;
          end
        end
        ST_POSTHPD: begin
          c.runTimer = 1'b1; c.limSel = LIM_POST;
          if (timerDone) nxt = ST_ENABLE;
        end
        ST_ENABLE: nxt = ST_ACTIVE;
        ST_ACTIVE: if (hpdFell) nxt = ST_HPDWAIT;
        default:   nxt = ST_IDLE;
      endcase
    end
    c.clrTimer = (nxt != st);
  end

  assign ctl = c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= nxt;
  end

  always_comb begin
    powerDown = (st == ST_IDLE);
    resetOut  = (st == ST_IDLE) || (st == ST_SUSRST) ||
                (st == ST_RST1) || (st == ST_RST2);
    ready     = (st == ST_ACTIVE);
    videoEn   = (st == ST_ENABLE);
  end

  // R9
  videoen_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    videoEn |=> !videoEn);

  // R9
  ready_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (videoEn && !suspendReq) |=> ready);

  // R7
  pd_after_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(powerDown) |-> $past(resetOut));

  // R8
  suspend_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (suspendReq && !powerDown) |=> (resetOut && !ready && !videoEn));

  // R10
  resume_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && resumeReq && !suspendReq && !hpdFell) |=> ready);
endmodule

// File: rtl/bridge_pwr_seq.sv
module bridge_pwr_seq import bps_pkg::*; #(
  parameter int RST1_MS     = 2,
  parameter int GAP_MS      = 50,
  parameter int RST2_MS     = 50,
  parameter int SETTLE_MS   = 200,
  parameter int HPD_TMO_MS  = 200,
  parameter int POST_HPD_MS = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tickMs,
  input  logic       resumeReq,
  input  logic       suspendReq,
  input  logic [7:0] gpioStatus,
  output logic       powerDown,
  output logic       resetOut,
  output logic       ready,
  output logic       videoEn,
  output logic       hpdWarn
);
  seqCtl_t ctl;
  logic    timerDone, firstPending, hpdLevel, hpdFell;

  bps_datapath #(
    .RST1_MS(RST1_MS), .GAP_MS(GAP_MS), .RST2_MS(RST2_MS),
    .SETTLE_MS(SETTLE_MS), .HPD_TMO_MS(HPD_TMO_MS), .POST_HPD_MS(POST_HPD_MS),
    .STAT_W(8), .HPD_BIT(1)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .tickMs(tickMs), .gpioStatus(gpioStatus),
    .ctl(ctl), .timerDone(timerDone), .firstPending(firstPending),
    .hpdLevel(hpdLevel), .hpdFell(hpdFell), .warnFlag(hpdWarn)
  );

  bps_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .resumeReq(resumeReq), .suspendReq(suspendReq),
    .timerDone(timerDone), .firstPending(firstPending), .hpdLevel(hpdLevel),
    .hpdFell(hpdFell), .ctl(ctl), .powerDown(powerDown), .resetOut(resetOut),
    .ready(ready), .videoEn(videoEn)
  );
endmodule

// File: tb/bridge_pwr_seq_bench.sv
module bridge_pwr_seq_bench;
  localparam int T1 = 2, TG = 50, T2 = 50, TS = 200, TH = 200, TP = 50;
  localparam int P_IDLE = 0, P_SR = 1, P_R1 = 2, P_GAP = 3, P_R2 = 4,
                 P_SET = 5, P_HW = 6, P_POST = 7, P_EN = 8, P_ACT = 9;

  logic clk = 1'b0, rst_n = 1'b0, tickMs = 1'b0;
  logic resumeReq = 1'b0, suspendReq = 1'b0;
  logic [7:0] gpioStatus = 8'h00;
  logic powerDown, resetOut, ready, videoEn, hpdWarn;

  int checks = 0, errors = 0, cyc = 0, tickDiv = 0;
  bit finished = 1'b0;

  // behavioural reference
  int phM = P_IDLE, remM = 0;
  bit firstM = 1'b0, warnM = 1'b0, prevM = 1'b0;

  always #4 clk = ~clk;

  bridge_pwr_seq u_bridge_pwr_seq (
    .clk(clk), .rst_n(rst_n), .tickMs(tickMs), .resumeReq(resumeReq),
    .suspendReq(suspendReq), .gpioStatus(gpioStatus), .powerDown(powerDown),
    .resetOut(resetOut), .ready(ready), .videoEn(videoEn), .hpdWarn(hpdWarn)
  );

  always @(negedge clk) begin
    tickDiv <= (tickDiv == 2) ? 0 : tickDiv + 1;
    tickMs  <= (tickDiv == 2);
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      phM = P_IDLE; firstM = 0; warnM = 0; prevM = 0; remM = 0;
    end else begin
      bit h;
      h = gpioStatus[1];
      if (suspendReq && phM != P_IDLE && phM != P_SR) phM = P_SR;
      else case (phM)
        P_IDLE: if (resumeReq && !suspendReq) begin phM = P_R1; remM = T1; warnM = 0; end
        P_SR:   phM = P_IDLE;
        P_R1, P_GAP, P_R2, P_SET, P_POST:
          if (tickMs) begin
            if (remM > 1) remM--;
            else case (phM)
              P_R1:  begin phM = P_GAP; remM = TG; end
              P_GAP: begin phM = P_R2;  remM = T2; end
              P_R2:  begin phM = P_SET; remM = TS; firstM = 1; end
              P_SET: begin phM = P_HW;  remM = TH; end
              default: phM = P_EN;
            endcase
          end
        P_HW:
          if (h) begin
            if (firstM) begin firstM = 0; phM = P_POST; remM = TP; end
            else phM = P_EN;
          end else if (tickMs) begin
            if (remM > 1) remM--;
            else begin warnM = 1; phM = P_EN; end
          end
        P_EN:  phM = P_ACT;
        default: if (prevM && !h) begin phM = P_HW; remM = TH; end
      endcase
      prevM = h;
    end
  end

  function automatic string tagOf(int p);
    case (p)
      P_IDLE: return "R1";
      P_SR:   return "R7";
      P_SET, P_HW: return "R3";
      P_POST: return "R4";
      P_EN, P_ACT: return "R9";
      default: return "R2";
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic [4:0] expV, actV;
      expV = {phM == P_IDLE,
              phM == P_IDLE || phM == P_SR || phM == P_R1 || phM == P_R2,
              phM == P_ACT, phM == P_EN, warnM};
      actV = {powerDown, resetOut, ready, videoEn, hpdWarn};
      checks++;
      if (actV !== expV) begin
        errors++;
        $display("FAIL %s (R6 for warn bit) cycle %0d: {pd,rst,rdy,ven,warn} actual=%b expected=%b",
                 tagOf(phM), cyc, actV, expV);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic waitPh(input int p);
    for (int i = 0; i < 5000; i++) begin
      if (phM == p) return;
      @(negedge clk);
    end
    errors++;
    $display("FAIL phase wait: actual=%0d expected=%0d", phM, p);
  endtask

  task automatic pulseResume();
    resumeReq = 1'b1; @(negedge clk); resumeReq = 1'b0;
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      report();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(powerDown && resetOut && !ready && !videoEn, "R1 in reset", {powerDown, resetOut}, 3);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(powerDown && resetOut && !hpdWarn, "R1 idle", {powerDown, resetOut, hpdWarn}, 6);

    // hot-plug low, other status bits high: R3 timeout path
    gpioStatus = 8'hFD;
    pulseResume();
    chk(!powerDown && resetOut, "R2 pd released first", {powerDown, resetOut}, 1);
    waitPh(P_SET);
    pulseResume();
    chk(!powerDown && !resetOut && !ready, "R10 resume during settle", {powerDown, resetOut}, 0);
    waitPh(P_EN);
    chk(hpdWarn && videoEn, "R6 timeout still enables", {hpdWarn, videoEn}, 3);
    @(negedge clk);
    chk(ready && !videoEn, "R9 ready after strobe", {ready, videoEn}, 2);
    pulseResume();
    chk(ready, "R10 resume while active", ready, 1);

    // first hot-plug after reset: extra delay
    gpioStatus = 8'h02; repeat (3) @(negedge clk);
    chk(ready, "R11 rise while active", ready, 1);
    gpioStatus = 8'h00; @(negedge clk);
    chk(!ready, "R11 fall drops ready", ready, 0);
    waitPh(P_HW);
    gpioStatus = 8'h02; @(negedge clk);
    chk(!videoEn && phM == P_POST, "R4 extra delay starts", videoEn, 0);
    waitPh(P_EN);
    chk(videoEn, "R4 strobe after delay", videoEn, 1);
    waitPh(P_ACT);

    // later hot-plug: immediate
    gpioStatus = 8'h00; @(negedge clk);
    gpioStatus = 8'h02; @(negedge clk);
    chk(videoEn, "R5 no extra delay", videoEn, 1);
    @(negedge clk);

    // suspend ordering
    suspendReq = 1'b1; @(negedge clk);
    chk(resetOut && !powerDown, "R7 reset first", {powerDown, resetOut}, 1);
    suspendReq = 1'b0; @(negedge clk);
    chk(resetOut && powerDown, "R7 then powerdown", {powerDown, resetOut}, 3);

    // resume with hot-plug already high
    pulseResume();
    chk(!hpdWarn, "R6 warn cleared by resume", hpdWarn, 0);
    waitPh(P_POST);
    chk(!ready && !resetOut, "R4 first hpd after new reset", ready, 0);
    waitPh(P_ACT);

    // abort mid-sequence, suspend wins over resume
    suspendReq = 1'b1; @(negedge clk); suspendReq = 1'b0; @(negedge clk);
    pulseResume();
    waitPh(P_GAP);
    suspendReq = 1'b1; resumeReq = 1'b1; @(negedge clk);
    chk(resetOut && !powerDown && !ready, "R8 abort during gap", {powerDown, resetOut}, 1);
    suspendReq = 1'b0; resumeReq = 1'b0; @(negedge clk);
    chk(powerDown && resetOut, "R8 back to idle", {powerDown, resetOut}, 3);
    repeat (10) @(negedge clk);
    chk(powerDown && !ready, "R8 stays idle", powerDown, 1);
    report();
  end
endmodule